// File: doc/BRIEF.md
# State Machine Dwell-Time Watchdog

This block supervises a protocol state machine from outside it. It sees only the supervised machine's current-state code. It never decodes that machine's logic, and nothing the machine does re-arms it. One counter measures how many consecutive clocks the machine has spent away from its IDLE code. When that stretch grows past a limit, the watchdog sends a one-clock force-to-IDLE pulse back to the machine.

A second counter can be enabled by a parameter. It measures how long the machine has sat in one particular non-IDLE code and fires the same pulse when that run grows past its own limit. This recovers a machine that entered a state such as an address phase, saw a single bus clock edge and then nothing more.

Every firing is logged in a diagnostic record. The record holds a sticky flag, the state code seen at the firing, which limits tripped, and a saturating firing count. A one-cycle clear input empties the record.

Top module: `fsm_dwell_guard`

## Requirements
- R1: After reset, force_idle_o, diag_fired_o, diag_state_o, diag_cause_o and diag_count_o are all zero.
- R2: A sample is the value of state_i taken at a rising clock edge. The away limit trips at the edge where state_i holds its (AWAY_LIMIT+1)-th consecutive non-IDLE sample; changes among non-IDLE codes do not restart this count. force_idle_o is then high in the following clock cycle.
- R3: Any sample equal to IDLE_CODE restarts the away count, so a non-IDLE run broken by a single IDLE sample never fires as long as each part is AWAY_LIMIT samples or shorter.
- R4: force_idle_o is never high for two cycles in a row. Every firing restarts both counts, so a machine that ignores the pulse is forced again after a further full limit.
- R5: With DWELL_EN=1, the dwell limit trips at the (DWELL_LIMIT+1)-th consecutive sample of one unchanged non-IDLE code. A change of code restarts this run. This covers a machine stuck in one state after a single bus edge.
- R6: On each firing, the record is updated at the same edge as the pulse. diag_fired_o is set, diag_state_o takes the sampled code, and diag_cause_o is loaded with bit 0 = away limit tripped and bit 1 = dwell limit tripped. Both bits may be set.
- R7: diag_count_o increments on each firing and saturates at 2^FIRE_CNT_W-1.
- R8: diag_clr_i high at an edge zeroes the whole record. If a firing happens at that same edge, the firing wins and the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| state_i | input | STATE_W | Current-state code of the supervised machine |
| diag_clr_i | input | 1 | One-cycle clear of the diagnostic record |
| force_idle_o | output | 1 | One-cycle force-to-IDLE pulse |
| diag_fired_o | output | 1 | Sticky flag: watchdog has fired |
| diag_state_o | output | STATE_W | State code sampled at the latest firing |
| diag_cause_o | output | 2 | Limits that tripped at the latest firing (bit 0 away, bit 1 dwell) |
| diag_count_o | output | FIRE_CNT_W | Saturating count of firings |

## Verification
Several properties are checked on every cycle. The forced pulse is never longer than one cycle. An IDLE sample always empties the away counter, which also never passes its limit. A change of code restarts the dwell run. Every pulse is matched by a set record, and the count holds at saturation and empties on a lone clear. Only the bench's scenarios can show the exact edge at which each limit trips, against run lengths swept across every value near both limits and against every state code. The same applies to the case where both limits trip together, to repeated firing of a machine that ignores the pulse, and to a clear that lands on the same edge as a firing.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int unsigned CAUSE_W     = 2;
  localparam int unsigned CAUSE_AWAY  = 0;
  localparam int unsigned CAUSE_DWELL = 1;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/away_timer.sv
module away_timer #(
  parameter int unsigned STATE_W   = 4,
  parameter int unsigned IDLE_CODE = 0,
  parameter int unsigned LIMIT     = 4096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               fire_i,
  output logic               trip_o
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [STATE_W-1:0] IDLE_C = STATE_W'(IDLE_CODE);
  localparam logic [CW-1:0]      LIM_C  = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          away;
  logic          cnt_en;

  assign away   = (state_i != IDLE_C);
  assign trip_o = away && (cnt_q >= LIM_C);
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    if (!away || fire_i)     cnt_d = '0;
    else if (cnt_q != '1)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_AWAY_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == IDLE_C) |=> (cnt_q == '0)); // R3
  AST_AWAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_C); // R2
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int unsigned STATE_W   = 4,
  parameter int unsigned IDLE_CODE = 0,
  parameter int unsigned LIMIT     = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_i,
  input  logic               fire_i,
  output logic               trip_o
);
  localparam int unsigned CW = $clog2(LIMIT + 2);
  localparam logic [STATE_W-1:0] IDLE_C = STATE_W'(IDLE_CODE);
  localparam logic [CW-1:0]      LIM_C  = CW'(LIMIT);

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [STATE_W-1:0] prev_q;
  logic               away, same;

  assign away   = (state_i != IDLE_C);
  assign same   = (state_i == prev_q);
  assign trip_o = away && same && (cnt_q >= LIM_C);

  always_comb begin
    cnt_d = cnt_q;
    if (!away || fire_i)   cnt_d = '0;
    else if (!same)        cnt_d = CW'(1);
    else if (cnt_q != '1)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= IDLE_C;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= state_i;
    end
  end

  AST_DWELL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (away && !same && !fire_i) |=> (cnt_q == CW'(1))); // R5
  AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_C); // R5
endmodule

// File: rtl/diag_record.sv
module diag_record
  import guard_pkg::*;
#(
  parameter int unsigned STATE_W    = 4,
  parameter int unsigned FIRE_CNT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fire_i,
  input  logic                  clr_i,
  input  logic [STATE_W-1:0]    state_i,
  input  cause_t                cause_i,
  output logic                  fired_o,
  output logic [STATE_W-1:0]    state_o,
  output cause_t                cause_o,
  output logic [FIRE_CNT_W-1:0] count_o
);
  logic                  fired_q, fired_d;
  logic [STATE_W-1:0]    state_q, state_d;
  cause_t                cause_q, cause_d;
  logic [FIRE_CNT_W-1:0] cnt_q, cnt_d;
  logic                  rec_en;

  assign rec_en = fire_i || clr_i;

  always_comb begin
    fired_d = fired_q;
    state_d = state_q;
    cause_d = cause_q;
    cnt_d   = cnt_q;
    if (fire_i) begin
      fired_d = 1'b1;
      state_d = state_i;
      cause_d = cause_i;
      if (clr_i)             cnt_d = FIRE_CNT_W'(1);
      else if (cnt_q != '1)  cnt_d = cnt_q + 1'b1;
    end else if (clr_i) begin
      fired_d = 1'b0;
      state_d = '0;
      cause_d = '0;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      state_q <= '0;
      cause_q <= '0;
      cnt_q   <= '0;
    end else if (rec_en) begin
      fired_q <= fired_d;
      state_q <= state_d;
      cause_q <= cause_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fired_o = fired_q;
  assign state_o = state_q;
  assign cause_o = cause_q;
  assign count_o = cnt_q;

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !clr_i) |=> (cnt_q == '1)); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fire_i) |=> (!fired_q && cnt_q == '0 && cause_q == '0)); // R8
endmodule

// File: rtl/fsm_dwell_guard.sv
module fsm_dwell_guard
  import guard_pkg::*;
#(
  parameter int unsigned STATE_W     = 4,
  parameter int unsigned IDLE_CODE   = 0,
  parameter int unsigned AWAY_LIMIT  = 4096,
  parameter int unsigned DWELL_LIMIT = 1024,
  parameter bit          DWELL_EN    = 1'b1,
  parameter int unsigned FIRE_CNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STATE_W-1:0]    state_i,
  input  logic                  diag_clr_i,
  output logic                  force_idle_o,
  output logic                  diag_fired_o,
  output logic [STATE_W-1:0]    diag_state_o,
  output logic [1:0]            diag_cause_o,
  output logic [FIRE_CNT_W-1:0] diag_count_o
);
  logic   away_trip, dwell_trip, fire;
  logic   force_q;
  cause_t cause;

  away_timer #(
    .STATE_W(STATE_W), .IDLE_CODE(IDLE_CODE), .LIMIT(AWAY_LIMIT)
  ) u_away (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .fire_i(fire), .trip_o(away_trip)
  );

  generate
    if (DWELL_EN) begin : g_dwell
      dwell_timer #(
        .STATE_W(STATE_W), .IDLE_CODE(IDLE_CODE), .LIMIT(DWELL_LIMIT)
      ) u_dwell (
        .clk(clk), .rst_n(rst_n), .state_i(state_i), .fire_i(fire), .trip_o(dwell_trip)
      );
    end else begin : g_no_dwell
      assign dwell_trip = 1'b0;
    end
  endgenerate

  assign fire = away_trip || dwell_trip;

  always_comb begin
    cause = '0;
    cause[CAUSE_AWAY]  = away_trip;
    cause[CAUSE_DWELL] = dwell_trip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) force_q <= 1'b0;
    else        force_q <= fire;
  end

  assign force_idle_o = force_q;

  diag_record #(
    .STATE_W(STATE_W), .FIRE_CNT_W(FIRE_CNT_W)
  ) u_diag (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .clr_i(diag_clr_i),
    .state_i(state_i), .cause_i(cause),
    .fired_o(diag_fired_o), .state_o(diag_state_o),
    .cause_o(diag_cause_o), .count_o(diag_count_o)
  );

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle_o |=> !force_idle_o); // R4
  AST_FIRE_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    force_idle_o |-> (diag_fired_o && diag_count_o != '0 && diag_cause_o != '0)); // R6
endmodule

// File: tb/fsm_dwell_guard_bench.sv
module fsm_dwell_guard_bench;
  localparam int AL = 12;
  localparam int DL = 5;
  localparam int CMAX = 7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] state_i;
  logic       diag_clr_i;
  logic       force_idle_o, diag_fired_o;
  logic [2:0] diag_state_o, diag_count_o;
  logic [1:0] diag_cause_o;

  int n_run = 0, n_fail = 0;
  int aw = 0, dw = 0, prv = 0;
  int mf = 0, ms = 0, mc = 0, mn = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fsm_dwell_guard #(
    .STATE_W(3), .IDLE_CODE(0), .AWAY_LIMIT(AL), .DWELL_LIMIT(DL),
    .DWELL_EN(1'b1), .FIRE_CNT_W(3)
  ) u_fsm_dwell_guard (
    .clk(clk), .rst_n(rst_n), .state_i(state_i), .diag_clr_i(diag_clr_i),
    .force_idle_o(force_idle_o), .diag_fired_o(diag_fired_o),
    .diag_state_o(diag_state_o), .diag_cause_o(diag_cause_o),
    .diag_count_o(diag_count_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One sample: drive, clock, update the requirement model, compare.
  task automatic step(input int code, input bit clr);
    bit nonidle, atrip, dtrip, fire;
    string t;
    state_i = 3'(code);
    diag_clr_i = clr;
    @(posedge clk); #1;
    nonidle = (code != 0);
    atrip = nonidle && (aw >= AL);                   // R2
    dtrip = nonidle && (code == prv) && (dw >= DL);  // R5
    fire  = atrip || dtrip;
    if (fire || !nonidle) aw = 0; else aw++;
    if (fire || !nonidle) dw = 0; else if (code == prv) dw++; else dw = 1;
    prv = code;
    if (fire) begin
      mf = 1; ms = code; mc = (dtrip ? 2 : 0) + (atrip ? 1 : 0);
      if (clr) mn = 1; else if (mn < CMAX) mn++;
    end else if (clr) begin
      mf = 0; ms = 0; mc = 0; mn = 0;
    end
    t = atrip ? "R2" : (dtrip ? "R5" : "R4");
    check(t, int'(force_idle_o), int'(fire));
    check("R6 fired", int'(diag_fired_o), mf);
    check("R6 state", int'(diag_state_o), ms);
    check("R6 cause", int'(diag_cause_o), mc);
    check(clr ? "R8 count" : "R7 count", int'(diag_count_o), mn);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; state_i = 3'd0; diag_clr_i = 1'b0;
    #23 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1
    check("R1 force", int'(force_idle_o), 0);
    check("R1 fired", int'(diag_fired_o), 0);
    check("R1 state", int'(diag_state_o), 0);
    check("R1 cause", int'(diag_cause_o), 0);
    check("R1 count", int'(diag_count_o), 0);

    // R2/R4: away-run sweep with code changing every sample
    for (int len = 1; len <= AL + 3; len++) begin
      for (int k = 0; k < len; k++) step((k % 7) + 1, 1'b0);
      step(0, 1'b0);
    end
    // R5: dwell sweep over every non-IDLE code (stuck after one edge)
    for (int c = 1; c <= 7; c++)
      for (int len = 1; len <= DL + 3; len++) begin
        for (int k = 0; k < len; k++) step(c, 1'b0);
        step(0, 1'b0);
      end
    // R3: runs split by one IDLE sample
    for (int gap = 1; gap <= AL; gap++) begin
      for (int k = 0; k < gap; k++) step((k % 7) + 1, 1'b0);
      step(0, 1'b0);
      for (int k = 0; k < AL; k++) step((k % 7) + 1, 1'b0);
      step(0, 1'b0);
    end
    // R4: machine ignores the pulse, keeps changing codes
    for (int k = 0; k < 4 * (AL + 1); k++) step((k % 7) + 1, 1'b0);
    step(0, 1'b0);
    // R6: both limits on the same edge
    for (int k = 0; k < 7; k++) step(k + 1, 1'b0);
    for (int k = 0; k < 8; k++) step(3, 1'b0);
    step(0, 1'b0);
    // R8: lone clear, then clear coinciding with a firing
    step(0, 1'b1);
    for (int k = 0; k < DL; k++) step(5, 1'b0);
    step(5, 1'b1);
    step(0, 1'b0);
    // R7: saturation of the firing count
    for (int k = 0; k < 12 * (DL + 1); k++) step(6, 1'b0);
    step(0, 1'b0);
    step(0, 1'b1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule